// File: doc/BRIEF.md
# Home-Node Coherence Request Sequencer

This block sits at the home node of a system whose caches talk over a point-to-point fabric instead of a shared bus. It puts the coherence requests for each memory block into one order. A node sends a Read or an Upgrade request that names itself and the block. The sequencer then does one of two things. If it accepts the request, it fans out a message to every other node: an invalidation for an Upgrade, or an intervention for a Read. If the request loses a race for the block, it returns a single negative acknowledgement (Nack) to the requester, which is expected to retry later.

The sequencer keeps two pieces of state per block: a write-busy mark and a count of outstanding reads. A write is outstanding until its requester sends a write-completion notice. The requester sends that notice after it has collected the invalidation acknowledgements, which go straight to it and never pass through this block. A Read stays counted until its own completion notice arrives. Several Reads to the same block may be in flight at once. An Upgrade is refused while any read or write on the block is outstanding. Outgoing messages leave through one valid/ready port at one destination per accepted handshake. The request port is a valid/ready port that accepts one request whenever no message sequence is pending.

Top module: `coh_seq_top`

## Requirements
- R1: After reset no message is offered (`out_valid`=0), `req_ready` is 1, and every block has no write outstanding and a read count of zero.
- R2: An Upgrade (`req_kind`=1) to a block with no outstanding read or write is accepted. It sets the write mark and produces one invalidation (`out_kind`=1) for every node except the requester, in ascending node order. Every message carries the requester in `out_src` and the block in `out_blk`.
- R3: A Read (`req_kind`=0) to a block with no outstanding write is accepted. It increments the read count and produces one intervention (`out_kind`=0) for every node except the requester, in ascending node order.
- R4: An Upgrade to a block with a write outstanding or a nonzero read count gets exactly one Nack (`out_kind`=2) addressed to the requester, and the block state does not change.
- R5: A Read to a block with a write outstanding gets exactly one Nack addressed to the requester.
- R6: A Read to a block that already has reads outstanding, and no write, is accepted without waiting for the earlier reads to complete.
- R7: A write-completion notice (`req_kind`=3) clears the block's write mark. A read-completion notice (`req_kind`=2) decrements its read count. An Upgrade is granted again only after all marks on the block are gone. Completion notices produce no message.
- R8: A Read to a block whose read count is at its maximum (2^RD_CNT_W−1) gets a Nack and leaves the count unchanged.
- R9: While a message sequence is pending, `req_ready` is 0. An offered message holds its kind, destination, source and block until `out_ready` accepts it.
- R10: Each block's marks are independent: requests for one block do not change the outcome for another.
- R11: A read-completion notice for a block whose read count is zero has no effect. The count stays zero, so a following Upgrade is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer can take a request |
| req_kind | input | 2 | 0 Read, 1 Upgrade, 2 read completion, 3 write completion |
| req_node | input | $clog2(NODES) | Requesting node |
| req_blk | input | $clog2(BLOCKS) | Block addressed |
| out_valid | output | 1 | Message offered |
| out_ready | input | 1 | Network takes the message |
| out_kind | output | 2 | 0 intervention, 1 invalidation, 2 Nack |
| out_dest | output | $clog2(NODES) | Destination node |
| out_src | output | $clog2(NODES) | Node whose request caused the message |
| out_blk | output | $clog2(BLOCKS) | Block concerned |

## Verification
A request is taken on the clock edge where `req_valid` and `req_ready` are both high. The first resulting message is offered from the next cycle on. Each later message follows the edge at which the previous one was accepted. The bench therefore samples one falling edge after the accepting edge. It then walks the expected destination list one accepted handshake at a time, with random `out_ready` stalls, and compares each held message on the following falling edge. Completion notices are checked by confirming that `out_valid` stays low on the falling edge after they are accepted. Their effect on the block state is checked through the outcome of the next Read or Upgrade, computed by a reference model inside the bench.

// File: rtl/coh_seq_pkg.sv
package coh_seq_pkg;

    typedef enum logic [1:0] {
        REQ_READ    = 2'd0,
        REQ_UPGRADE = 2'd1,
        REQ_RD_DONE = 2'd2,
        REQ_WR_DONE = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        MSG_INTERVENE  = 2'd0,
        MSG_INVALIDATE = 2'd1,
        MSG_NACK       = 2'd2
    } msg_kind_e;

    typedef struct packed {
        logic launch;   // request accepted, broadcast needed
        logic refuse;   // request lost the race, Nack needed
    } verdict_t;

    function automatic msg_kind_e fanout_kind(req_kind_e k);
        return (k == REQ_UPGRADE) ? MSG_INVALIDATE : MSG_INTERVENE;
    endfunction

endpackage

// File: rtl/coh_seq_track.sv
module coh_seq_track
    import coh_seq_pkg::*;
#(
    parameter int BLOCKS   = 16,
    parameter int RD_CNT_W = 2,
    localparam int BLK_W   = $clog2(BLOCKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc,
    input  req_kind_e        kind,
    input  logic [BLK_W-1:0] blk,
    output verdict_t         verdict
);

    logic                wr_mark [BLOCKS];
    logic [RD_CNT_W-1:0] rd_cnt  [BLOCKS];

    logic                cur_wr;
    logic [RD_CNT_W-1:0] cur_cnt;

    always_comb begin
        cur_wr         = wr_mark[blk];
        cur_cnt        = rd_cnt[blk];
        verdict        = '0;
        unique case (kind)
            REQ_READ: begin
                verdict.refuse = cur_wr || (&cur_cnt);
                verdict.launch = !verdict.refuse;
            end
            REQ_UPGRADE: begin
                verdict.refuse = cur_wr || (cur_cnt != '0);
                verdict.launch = !verdict.refuse;
            end
            default: verdict = '0;
        endcase
    end

    for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
        logic hit;
        assign hit = acc && (blk == BLK_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                wr_mark[b] <= 1'b0;
                rd_cnt[b]  <= '0;
            end else if (hit) begin
                unique case (kind)
                    REQ_READ:    if (verdict.launch) rd_cnt[b] <= rd_cnt[b] + 1'b1;
                    REQ_UPGRADE: if (verdict.launch) wr_mark[b] <= 1'b1;
                    REQ_RD_DONE: if (rd_cnt[b] != '0) rd_cnt[b] <= rd_cnt[b] - 1'b1;
                    REQ_WR_DONE: wr_mark[b] <= 1'b0;
                    default: ;
                endcase
            end
        end

        // R4: a write and reads never share a block
        a_r4_excl: assert property (@(posedge clk) disable iff (rst)
            wr_mark[b] |-> (rd_cnt[b] == '0));

        // R8: an accepted read never wraps the counter to zero
        a_r8_no_wrap: assert property (@(posedge clk) disable iff (rst)
            (hit && kind == REQ_READ && verdict.launch) |=> (rd_cnt[b] != '0));

        // R11: a completion on an idle count leaves it at zero
        a_r11_no_underflow: assert property (@(posedge clk) disable iff (rst)
            (hit && kind == REQ_RD_DONE && rd_cnt[b] == '0) |=> (rd_cnt[b] == '0));
    end

endmodule

// File: rtl/coh_seq_walk.sv
module coh_seq_walk
    import coh_seq_pkg::*;
#(
    parameter int NODES  = 8,
    parameter int BLOCKS = 16,
    localparam int NODE_W = $clog2(NODES),
    localparam int BLK_W  = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              single,
    input  msg_kind_e         kind_in,
    input  logic [NODE_W-1:0] src_in,
    input  logic [BLK_W-1:0]  blk_in,
    input  logic              out_ready,
    output logic              out_valid,
    output msg_kind_e         out_kind,
    output logic [NODE_W-1:0] out_dest,
    output logic [NODE_W-1:0] out_src,
    output logic [BLK_W-1:0]  out_blk,
    output logic              busy
);

    logic              active;
    logic              single_q;
    msg_kind_e         kind_q;
    logic [NODE_W-1:0] src_q;
    logic [NODE_W-1:0] dest_q;
    logic [BLK_W-1:0]  blk_q;

    logic [NODE_W:0]   step1;
    logic [NODE_W:0]   step2;
    logic              last;

    always_comb begin
        step1 = {1'b0, dest_q} + 1'b1;
        step2 = (step1 == {1'b0, src_q}) ? step1 + 1'b1 : step1;
        last  = single_q || (step2 >= (NODE_W+1)'(NODES));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            single_q <= 1'b0;
            kind_q   <= MSG_INTERVENE;
            src_q    <= '0;
            dest_q   <= '0;
            blk_q    <= '0;
        end else if (start) begin
            active   <= 1'b1;
            single_q <= single;
            kind_q   <= single ? MSG_NACK : kind_in;
            src_q    <= src_in;
            blk_q    <= blk_in;
            if (single)            dest_q <= src_in;
            else if (src_in == '0) dest_q <= NODE_W'(1);
            else                   dest_q <= '0;
        end else if (active && out_ready) begin
            if (last) active <= 1'b0;
            else      dest_q <= step2[NODE_W-1:0];
        end
    end

    assign out_valid = active;
    assign out_kind  = kind_q;
    assign out_dest  = dest_q;
    assign out_src   = src_q;
    assign out_blk   = blk_q;
    assign busy      = active;

    // R2: a broadcast never lands on the requester
    a_r2_skip_src: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind != MSG_NACK) |-> (out_dest != out_src));

    // R4: a Nack goes back to the requester
    a_r4_nack_home: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_kind == MSG_NACK) |-> (out_dest == out_src));

    // R9: an offered message holds until taken
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_dest)
                                       && $stable(out_kind) && $stable(out_blk)));

    // R9: no new sequence while one is pending
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        start |-> !active);

endmodule

// File: rtl/coh_seq_top.sv
module coh_seq_top
    import coh_seq_pkg::*;
#(
    parameter int NODES    = 8,
    parameter int BLOCKS   = 16,
    parameter int RD_CNT_W = 2,
    localparam int NODE_W  = $clog2(NODES),
    localparam int BLK_W   = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [NODE_W-1:0] req_node,
    input  logic [BLK_W-1:0]  req_blk,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_kind,
    output logic [NODE_W-1:0] out_dest,
    output logic [NODE_W-1:0] out_src,
    output logic [BLK_W-1:0]  out_blk
);

    req_kind_e kind;
    verdict_t  verdict;
    logic      acc;
    logic      walk_busy;
    msg_kind_e walk_kind;

    assign kind      = req_kind_e'(req_kind);
    assign req_ready = !walk_busy;
    assign acc       = req_valid && req_ready;

    coh_seq_track #(
        .BLOCKS   (BLOCKS),
        .RD_CNT_W (RD_CNT_W)
    ) u_track (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .kind    (kind),
        .blk     (req_blk),
        .verdict (verdict)
    );

    coh_seq_walk #(
        .NODES  (NODES),
        .BLOCKS (BLOCKS)
    ) u_walk (
        .clk       (clk),
        .rst       (rst),
        .start     (acc && (verdict.launch || verdict.refuse)),
        .single    (verdict.refuse),
        .kind_in   (fanout_kind(kind)),
        .src_in    (req_node),
        .blk_in    (req_blk),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_kind  (walk_kind),
        .out_dest  (out_dest),
        .out_src   (out_src),
        .out_blk   (out_blk),
        .busy      (walk_busy)
    );

    assign out_kind = walk_kind;

    // R9: request port closed while messages are pending
    a_r9_ready_closed: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !req_ready);

    // R7: completion notices never start a message sequence
    a_r7_silent_done: assert property (@(posedge clk) disable iff (rst)
        (acc && req_kind[1]) |=> !out_valid);

endmodule

// File: tb/coh_seq_top_bench.sv
module coh_seq_top_bench;

    localparam int NODES = 8;
    localparam int BLOCKS = 16;
    localparam int CMAX = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_kind = 2'd0;
    logic [2:0] req_node = 3'd0;
    logic [3:0] req_blk = 4'd0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [1:0] out_kind;
    logic [2:0] out_dest;
    logic [2:0] out_src;
    logic [3:0] out_blk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    int m_wr  [BLOCKS];
    int m_cnt [BLOCKS];
    int exp_kind [NODES];
    int exp_dest [NODES];
    int exp_n;

    always #2.5 clk = ~clk;

    coh_seq_top u_coh_seq_top (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_node(req_node), .req_blk(req_blk),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
        .out_dest(out_dest), .out_src(out_src), .out_blk(out_blk)
    );

    task automatic chk(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // reference: outcome of a request, and model update
    function automatic void predict(int k, int n, int b);
        bit nack = 0;
        exp_n = 0;
        case (k)
            0: if (m_wr[b] != 0 || m_cnt[b] == CMAX) nack = 1;
               else m_cnt[b]++;
            1: if (m_wr[b] != 0 || m_cnt[b] != 0) nack = 1;
               else m_wr[b] = 1;
            2: if (m_cnt[b] > 0) m_cnt[b]--;
            default: m_wr[b] = 0;
        endcase
        if (k >= 2) return;
        if (nack) begin
            exp_kind[0] = 2; exp_dest[0] = n; exp_n = 1;
        end else begin
            for (int d = 0; d < NODES; d++)
                if (d != n) begin
                    exp_kind[exp_n] = (k == 1) ? 1 : 0;
                    exp_dest[exp_n] = d;
                    exp_n++;
                end
        end
    endfunction

    task automatic do_req(int k, int n, int b, string tag);
        int got = 0;
        int guard = 0;
        predict(k, n, b);
        @(negedge clk);
        chk(req_ready == 1'b1, {tag, " R9 ready before request"}, int'(req_ready), 1);
        req_valid = 1'b1; req_kind = 2'(k); req_node = 3'(n); req_blk = 4'(b);
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_n == 0) begin
            chk(out_valid == 1'b0, {tag, " R7 completion silent"}, int'(out_valid), 0);
        end else begin
            chk(req_ready == 1'b0, {tag, " R9 ready low while pending"}, int'(req_ready), 0);
        end
        while (got < exp_n && guard < 200) begin
            bit rdy = (($urandom % 4) != 0);
            guard++;
            out_ready = rdy;
            if (!out_valid) begin
                chk(0, {tag, " message missing"}, 0, 1);
                break;
            end
            if (rdy) begin
                chk(int'(out_kind) == exp_kind[got], {tag, " kind"}, int'(out_kind), exp_kind[got]);
                chk(int'(out_dest) == exp_dest[got], {tag, " dest"}, int'(out_dest), exp_dest[got]);
                chk(int'(out_src) == n && int'(out_blk) == b, {tag, " R2 src/blk"},
                    int'(out_src) * 100 + int'(out_blk), n * 100 + b);
                got++;
                @(negedge clk);
            end else begin
                logic [2:0] hd = out_dest;
                logic [1:0] hk = out_kind;
                @(negedge clk);
                chk(out_valid && out_dest == hd && out_kind == hk, {tag, " R9 hold under stall"},
                    int'(out_dest), int'(hd));
            end
        end
        out_ready = 1'b0;
        chk(out_valid == 1'b0 && req_ready == 1'b1, {tag, " sequence ended"},
            int'(out_valid), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < BLOCKS; i++) begin m_wr[i] = 0; m_cnt[i] = 0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 no message after reset", int'(out_valid), 0);
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

        do_req(1, 3, 0, "R1 R2 upgrade free block");
        do_req(1, 5, 0, "R4 upgrade vs write");
        do_req(0, 2, 0, "R5 read vs write");
        do_req(0, 1, 1, "R10 R3 read other block");
        do_req(3, 3, 0, "R7 write done");
        do_req(1, 6, 0, "R7 upgrade after done");
        do_req(3, 6, 0, "R7 write done again");
        do_req(0, 0, 2, "R3 first read");
        do_req(0, 7, 2, "R6 overlapping read");
        do_req(1, 4, 2, "R4 upgrade vs reads");
        do_req(2, 0, 2, "R7 one read done");
        do_req(1, 4, 2, "R4 upgrade vs remaining read");
        do_req(2, 7, 2, "R7 last read done");
        do_req(1, 4, 2, "R7 upgrade after reads done");
        do_req(3, 4, 2, "R7 release");
        do_req(0, 1, 3, "R8 read one");
        do_req(0, 2, 3, "R8 read two");
        do_req(0, 3, 3, "R8 read three");
        do_req(0, 4, 3, "R8 read at max");
        do_req(2, 5, 4, "R11 stray read done");
        do_req(1, 5, 4, "R11 upgrade after stray");

        for (int i = 0; i < 300; i++) begin
            int r = $urandom % 10;
            int k = (r < 4) ? 0 : (r < 6) ? 1 : (r < 8) ? 2 : 3;
            do_req(k, $urandom % NODES, $urandom % 6, "R6 R10 random mix");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule